// File: doc/BRIEF.md
# Address-Masked GPIO Register Port

This block is an eight-pin general-purpose I/O port sitting behind a small memory-mapped register bus. Software sets each pin's direction, writes output levels, reads pin levels back and stores a per-pin mode-select byte. The port drives the output levels and their output-enable signals, and it samples the input pins through a two-flop synchronizer.

Any access to the data window (byte offsets below 0x400) uses byte-offset bits [9:2] as a per-pin mask. A write changes only pins that are enabled in that mask and configured as outputs. This lets software change single pins with one store and no read-modify-write. A read of the data window returns only the masked pins. A fixed set of identification bytes can be read near the top of the 4 KiB window.

The bus is a single-cycle request: `bus_valid` qualifies the request, and `bus_write` selects a write or a read. Read data is registered at the edge that accepts the read. It then holds until the next read.

Top module: `gpio_port`

## Requirements
- R1: Reset clears the direction, data and mode-select registers, so `pin_out`, `pin_oe` and `mode_sel` read 0. It also clears `bus_rdata` to 0.
- R2: The direction register sits at byte offset 0x400 and keeps wdata[7:0]. A 1 makes a pin an output. The register drives `pin_oe` directly, and it reads back with bits [31:8] as zero.
- R3: A write at any byte offset below 0x400 updates data bit i only when offset bit (i+2) is 1 and direction bit i is 1. The bit takes the value of wdata bit i, and every other data bit keeps its value. The data register drives `pin_out`. Writes outside the data window never change `pin_out`.
- R4: Writing a data bit whose pin is an input leaves the stored bit unchanged. This stays true even when the mask selects that bit. The old value appears when the pin is later made an output.
- R5: A read below 0x400 returns, for each pin i whose offset bit (i+2) is 1, the stored data bit for an output pin or the synchronized input level for an input pin. All other bits read as 0.
- R6: After an input pin changes between two clock edges, a read accepted at the first or second following edge returns the old level. A read accepted at the third edge returns the new level.
- R7: The mode-select register sits at byte offset 0x420. It keeps wdata[7:0], drives `mode_sel` and reads back with bits [31:8] as zero.
- R8: Offsets 0xFE0, 0xFE4, …, 0xFFC read the identification bytes 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order, in bits [7:0], with bits [31:8] as zero. Writes there have no effect.
- R9: Reads of any other offset return 0. Writes to any other offset change no output. Examples are 0x404 and 0x800.
- R10: `bus_rdata` changes only on the clock edge that accepts a read. It holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request qualifier |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output levels (data register) |
| pin_oe | output | 8 | Output enables (direction register) |
| mode_sel | output | 8 | Stored mode-select bits |

## Verification
The assertions check the following on every cycle:
- the masked write rule against the previous `pin_out` and `pin_oe`;
- that direction and mode-select writes land the next cycle;
- that non-data writes leave `pin_out` untouched;
- that data reads never expose unmasked bits;
- that ID reads carry a clear upper field;
- that `bus_rdata` holds when no read is accepted.

Some behaviours only the bench scenarios can show:
- the exact ID byte values;
- the two-edge synchronizer delay;
- the persistence of a blocked input-pin write until the pin becomes an output;
- zero returns from unmapped offsets.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int GP_PINS = 8;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_DATA,
    RG_DIR,
    RG_MODE,
    RG_ID
  } region_e;

  // Data-window word offsets and register word offsets (byte offset >> 2)
  localparam logic [9:0] WORD_DIR  = 10'h100;
  localparam logic [9:0] WORD_MODE = 10'h108;
  localparam logic [9:0] WORD_ID0  = 10'h3F8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h61;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  // New data value after a masked write: only masked output bits move
  function automatic logic [GP_PINS-1:0] masked_update(
    input logic [GP_PINS-1:0] cur,
    input logic [GP_PINS-1:0] wval,
    input logic [GP_PINS-1:0] amask,
    input logic [GP_PINS-1:0] dir
  );
    logic [GP_PINS-1:0] en;
    en = amask & dir;
    masked_update = (cur & ~en) | (wval & en);
  endfunction

  // Value seen by a data read: outputs from the register, inputs from the pins
  function automatic logic [GP_PINS-1:0] masked_view(
    input logic [GP_PINS-1:0] stored,
    input logic [GP_PINS-1:0] level,
    input logic [GP_PINS-1:0] amask,
    input logic [GP_PINS-1:0] dir
  );
    masked_view = ((stored & dir) | (level & ~dir)) & amask;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [2:0]        id_idx
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word   = addr[ADDR_W-1:2];
  assign id_idx = addr[4:2];

  always_comb begin
    if (addr[ADDR_W-1:10] == '0)             region = RG_DATA;
    else if (word == WORD_W'(WORD_DIR))      region = RG_DIR;
    else if (word == WORD_W'(WORD_MODE))     region = RG_MODE;
    else if (word >= WORD_W'(WORD_ID0))      region = RG_ID;
    else                                     region = RG_NONE;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PINS        = GP_PINS,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   mode_sel
);

  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + PINS - 1;

  region_e          region;
  logic [2:0]       id_idx;
  logic [PINS-1:0]  pin_sync;
  logic [PINS-1:0]  addr_mask;
  logic [PINS-1:0]  data_q, dir_q, mode_q;
  logic             wr_req, rd_req;
  logic             wr_data, wr_dir, wr_mode;
  logic [DATA_W-1:0] rd_value;

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .region (region),
    .id_idx (id_idx)
  );

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  assign addr_mask = bus_addr[MASK_HI:MASK_LO];
  assign wr_req    = bus_valid &&  bus_write;
  assign rd_req    = bus_valid && !bus_write;
  assign wr_data   = wr_req && (region == RG_DATA);
  assign wr_dir    = wr_req && (region == RG_DIR);
  assign wr_mode   = wr_req && (region == RG_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_data) data_q <= masked_update(data_q, bus_wdata[PINS-1:0], addr_mask, dir_q);
      if (wr_dir)  dir_q  <= bus_wdata[PINS-1:0];
      if (wr_mode) mode_q <= bus_wdata[PINS-1:0];
    end
  end

  always_comb begin
    rd_value = '0;
    case (region)
      RG_DATA: rd_value[PINS-1:0] = masked_view(data_q, pin_sync, addr_mask, dir_q);
      RG_DIR:  rd_value[PINS-1:0] = dir_q;
      RG_MODE: rd_value[PINS-1:0] = mode_q;
      RG_ID:   rd_value[7:0]      = id_byte(id_idx);
      default: rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_value;
  end

  assign pin_out  = data_q;
  assign pin_oe   = dir_q;
  assign mode_sel = mode_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PINS   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   mode_sel
);

  logic in_data, at_dir, at_mode, at_id;
  assign in_data = (bus_addr[ADDR_W-1:10] == '0);
  assign at_dir  = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(10'h100));
  assign at_mode = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(10'h108));
  assign at_id   = (bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(10'h3F8));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && at_dir) |=> (pin_oe == $past(bus_wdata[PINS-1:0])));

  p_masked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && in_data) |=>
      (((pin_out ^ $past(pin_out)) & ~($past(bus_addr[PINS+1:2]) & $past(pin_oe))) == '0) &&
      (((pin_out ^ $past(bus_wdata[PINS-1:0])) & $past(bus_addr[PINS+1:2]) & $past(pin_oe)) == '0));

  p_input_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && in_data) |=>
      (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  p_nondata_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !in_data) |=> $stable(pin_out));

  p_read_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && in_data) |=>
      ((bus_rdata & ~DATA_W'($past(bus_addr[PINS+1:2]))) == '0));

  p_mode_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && at_mode) |=> (mode_sel == $past(bus_wdata[PINS-1:0])));

  p_id_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && at_id) |=> (bus_rdata[DATA_W-1:8] == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind gpio_port gpio_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mode_sel  (mode_sel)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, mode_sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .mode_sel(mode_sel)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  pins;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h400, 32'h0000_00F0, 8'h00, 32'h0, 8'd2},
    '{1'b0, 12'h400, 32'h0,         8'h00, 32'h0000_00F0, 8'd2},
    '{1'b1, 12'h3FC, 32'hFFFF_FFFF, 8'h00, 32'h0, 8'd3},
    '{1'b0, 12'h3FC, 32'h0,         8'h05, 32'h0000_00F5, 8'd5},
    '{1'b1, 12'h040, 32'h0000_0000, 8'h05, 32'h0, 8'd3},
    '{1'b0, 12'h3FC, 32'h0,         8'h05, 32'h0000_00E5, 8'd3},
    '{1'b0, 12'h0C0, 32'h0,         8'h05, 32'h0000_0020, 8'd5},
    '{1'b1, 12'h03C, 32'h0000_000F, 8'h00, 32'h0, 8'd4},
    '{1'b1, 12'h400, 32'h0000_00FF, 8'h00, 32'h0, 8'd4},
    '{1'b0, 12'h3FC, 32'h0,         8'hFF, 32'h0000_00E0, 8'd4},
    '{1'b1, 12'h420, 32'h0000_00A5, 8'h00, 32'h0, 8'd7},
    '{1'b0, 12'h420, 32'h0,         8'h00, 32'h0000_00A5, 8'd7},
    '{1'b0, 12'hFE0, 32'h0,         8'h00, 32'h0000_0061, 8'd8},
    '{1'b0, 12'hFFC, 32'h0,         8'h00, 32'h0000_00B1, 8'd8},
    '{1'b0, 12'hFF0, 32'h0,         8'h00, 32'h0000_000D, 8'd8},
    '{1'b1, 12'hFE0, 32'h0000_0000, 8'h00, 32'h0, 8'd8},
    '{1'b0, 12'hFE0, 32'h0,         8'h00, 32'h0000_0061, 8'd8},
    '{1'b1, 12'h404, 32'h0000_00FF, 8'h00, 32'h0, 8'd9},
    '{1'b0, 12'h404, 32'h0,         8'h00, 32'h0000_0000, 8'd9},
    '{1'b0, 12'h800, 32'h0,         8'h00, 32'h0000_0000, 8'd9},
    '{1'b1, 12'h400, 32'h0000_0123, 8'h00, 32'h0, 8'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 pin_out", {24'h0, pin_out}, 32'h0);
    check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R1 mode_sel", {24'h0, mode_sel}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      pin_in = VECS[i].pins;
      repeat (3) @(negedge clk);
      bus_op(VECS[i].wr, VECS[i].addr, VECS[i].data);
      if (!VECS[i].wr) check($sformatf("R%0d vec%0d", VECS[i].req, i), bus_rdata, VECS[i].exp);
    end

    // R2/R3/R7/R9: outputs after the table
    check("R2 pin_oe", {24'h0, pin_oe}, 32'h23);
    check("R3 pin_out", {24'h0, pin_out}, 32'hE0);
    check("R7 mode_sel", {24'h0, mode_sel}, 32'hA5);
    bus_op(1'b0, 12'h400, 32'h0);
    check("R2 readback upper zero", bus_rdata, 32'h23);

    // R6: synchronizer latency, all pins inputs
    bus_op(1'b1, 12'h400, 32'h0);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    pin_in = 8'h01;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h004;
    @(negedge clk);
    check("R6 first edge old", bus_rdata, 32'h0);
    @(negedge clk);
    check("R6 second edge old", bus_rdata, 32'h0);
    @(negedge clk);
    check("R6 third edge new", bus_rdata, 32'h1);
    bus_valid = 1'b0;

    // R10: rdata holds through a write and idle cycles
    bus_op(1'b1, 12'h420, 32'h0000_005A);
    repeat (3) @(negedge clk);
    check("R10 rdata hold", bus_rdata, 32'h1);
    check("R7 second mode write", {24'h0, mode_sel}, 32'h5A);

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 re-reset mode_sel", {24'h0, mode_sel}, 32'h0);
    check("R1 re-reset rdata", bus_rdata, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule